// File: doc/BRIEF.md
# Processor Register File with Exception State

This block holds the architectural integer registers of a 32-bit RISC core together with the small amount of state needed to take and return from an interrupt. Two operand values are read combinationally, each selected by its own 5-bit index. One result is written on the rising clock edge to the register selected by a 5-bit destination index. Index 0 is a constant zero: it is not stored, it always reads as zero, and writes to it have no effect.

Next to the general registers sit a 32-bit exception return address and a one-bit interrupt enable flag. Both are visible on outputs at all times. Dedicated move operations load them from the write data bus. Taking an interrupt captures the interrupted address and clears the flag in one edge. A return-from-exception sets the flag again. Forwarding, vector generation and the rest of the pipeline live outside this block.

Top module: `regfile_top`

## Requirements
- R1: While rst_ni is low, every general register, the return address and the enable flag read as zero. The flag comes out of reset at 0.
- R2: A read with index 0 returns zero on either read port, whatever has been written before.
- R3: When wr_en_i is high and wr_idx_i is not 0, wr_data_i is stored at the rising edge. From the next cycle on, it is returned by any read port whose index equals wr_idx_i.
- R4: A write with wr_idx_i equal to 0 changes no register. Index 0 still reads zero and all other registers keep their values.
- R5: A read of the register that is being written in the same cycle returns the value held before that edge.
- R6: The two read ports are independent: each returns the register selected by its own index in the same cycle.
- R7: When irq_take_i is high, the next edge stores irq_pc_i as the return address and clears the enable flag. This takes priority over eret_i, epc_wr_i and stat_wr_i in the same cycle.
- R8: When eret_i is high and irq_take_i is low, the next edge sets the enable flag to 1. This takes priority over stat_wr_i.
- R9: When epc_wr_i is high and irq_take_i is low, the return address is loaded from wr_data_i. When stat_wr_i is high and neither irq_take_i nor eret_i is high, the flag is loaded from wr_data_i bit 0.
- R10: epc_o and irq_en_o show the stored return address and flag continuously. They change only at an edge where R7, R8 or R9 applies.
- R11: With wr_en_i low, no general register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_idx_i | input | 5 | Source read index |
| rt_idx_i | input | 5 | Target read index |
| rs_data_o | output | 32 | Source read value |
| rt_data_o | output | 32 | Target read value |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 5 | Destination index |
| wr_data_i | input | 32 | Write data, also source for the moves |
| epc_wr_i | input | 1 | Move write data into the return address |
| stat_wr_i | input | 1 | Move write data bit 0 into the enable flag |
| eret_i | input | 1 | Return from exception, sets the flag |
| irq_take_i | input | 1 | Interrupt taken this cycle |
| irq_pc_i | input | 32 | Address to save on interrupt |
| epc_o | output | 32 | Stored return address |
| irq_en_o | output | 1 | Interrupt enable flag |

## Verification
Two collisions can occur in one cycle. The first is an interrupt arriving together with a move to the return address, a move to the flag or a return-from-exception. The second is a general register being read in the same cycle it is written. The bench drives both on purpose in directed cycles, then mixes them in random traffic that includes all exception controls. A behavioural model that applies the stated priorities and old-value read rule judges the outputs every cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned NUM_REGS_DEF = 32;

  typedef struct packed {
    logic irq;
    logic eret;
    logic epc_wr;
    logic stat_wr;
  } exc_req_t;
endpackage

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   waddr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);
  assign regs_o[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && waddr_i == IDX_W'(g))      q <= wdata_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [DATA_W-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    if (idx_i != '0 && 32'(idx_i) < NUM_REGS) data_o = regs_i[idx_i];
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  exc_req_t          req_i,
  input  logic [DATA_W-1:0] irq_pc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] epc_o,
  output logic              irq_en_o
);
  logic [DATA_W-1:0] epc_q, epc_d;
  logic              en_q, en_d;

  // priority: interrupt > eret > move
  always_comb begin
    epc_d = epc_q;
    en_d  = en_q;
    if (req_i.irq) begin
      epc_d = irq_pc_i;
      en_d  = 1'b0;
    end else begin
      if (req_i.epc_wr)     epc_d = wdata_i;
      if (req_i.eret)       en_d  = 1'b1;
      else if (req_i.stat_wr) en_d = wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      epc_q <= epc_d;
      en_q  <= en_d;
    end
  end

  assign epc_o    = epc_q;
  assign irq_en_o = en_q;
endmodule

// File: rtl/regfile_top.sv
module regfile_top
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned NUM_REGS = NUM_REGS_DEF,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  output logic [DATA_W-1:0] rs_data_o,
  output logic [DATA_W-1:0] rt_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              epc_wr_i,
  input  logic              stat_wr_i,
  input  logic              eret_i,
  input  logic              irq_take_i,
  input  logic [DATA_W-1:0] irq_pc_i,
  output logic [DATA_W-1:0] epc_o,
  output logic              irq_en_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  exc_req_t                        req;

  gpr_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_idx_i),
    .wdata_i (wr_data_i),
    .regs_o  (regs)
  );

  gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_rs (
    .regs_i (regs),
    .idx_i  (rs_idx_i),
    .data_o (rs_data_o)
  );

  gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_rt (
    .regs_i (regs),
    .idx_i  (rt_idx_i),
    .data_o (rt_data_o)
  );

  assign req = '{irq: irq_take_i, eret: eret_i, epc_wr: epc_wr_i, stat_wr: stat_wr_i};

  exc_state #(.DATA_W(DATA_W)) u_exc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .irq_pc_i (irq_pc_i),
    .wdata_i  (wr_data_i),
    .epc_o    (epc_o),
    .irq_en_o (irq_en_o)
  );
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rs_idx_i,
  input logic [IDX_W-1:0]  rt_idx_i,
  input logic [DATA_W-1:0] rs_data_o,
  input logic [DATA_W-1:0] rt_data_o,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              epc_wr_i,
  input logic              stat_wr_i,
  input logic              eret_i,
  input logic              irq_take_i,
  input logic [DATA_W-1:0] irq_pc_i,
  input logic [DATA_W-1:0] epc_o,
  input logic              irq_en_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  p_zero_rs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_idx_i == '0 |-> rs_data_o == '0);

  p_zero_rt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_idx_i == '0 |-> rt_data_o == '0);

  p_write_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(wr_en_i && wr_idx_i != '0) && rs_idx_i == $past(wr_idx_i)
    |-> rs_data_o == $past(wr_data_i));

  p_irq_save_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> epc_o == $past(irq_pc_i) && !irq_en_o);

  p_eret_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !irq_take_i |=> irq_en_o);

  p_stat_move_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !eret_i && !irq_take_i |=> irq_en_o == $past(wr_data_i[0]));

  p_epc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_take_i && !epc_wr_i |=> $stable(epc_o));
endmodule

bind regfile_top regfile_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/tb_regfile_top.sv
`timescale 1ns/1ps
module tb_regfile_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rs_idx_i = '0, rt_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rs_data_o, rt_data_o, wr_data_i = '0, irq_pc_i = '0, epc_o;
  logic        wr_en_i = 0, epc_wr_i = 0, stat_wr_i = 0, eret_i = 0, irq_take_i = 0;
  logic        irq_en_o;

  always #2.5 clk_i = ~clk_i;

  regfile_top dut (.*);

  logic [31:0] m_gpr [32];
  logic [31:0] m_epc;
  logic        m_en;
  int          checks = 0, errors = 0;
  string       tag = "R1";
  bit          done = 0;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic clr();
    wr_en_i = 0; epc_wr_i = 0; stat_wr_i = 0; eret_i = 0; irq_take_i = 0;
  endtask

  // inputs already set at negedge: check, then advance model at the edge
  task automatic cyc();
    logic [31:0] prev [32];
    #1;
    chk({tag, " rs"}, rs_data_o, (rs_idx_i == 0) ? 32'h0 : m_gpr[rs_idx_i]);
    chk({tag, " rt"}, rt_data_o, (rt_idx_i == 0) ? 32'h0 : m_gpr[rt_idx_i]);
    chk({tag, " epc"}, epc_o, m_epc);
    chk({tag, " en"}, {31'h0, irq_en_o}, {31'h0, m_en});
    prev = m_gpr;
    @(posedge clk_i);
    if (rst_ni) begin
      if (wr_en_i && wr_idx_i != 0) m_gpr[wr_idx_i] = wr_data_i;
      if (irq_take_i) begin
        m_epc = irq_pc_i; m_en = 0;
      end else begin
        if (epc_wr_i) m_epc = wr_data_i;
        if (eret_i) m_en = 1;
        else if (stat_wr_i) m_en = wr_data_i[0];
      end
    end
    @(negedge clk_i);
    if (prev[0] !== 32'h0) chk("R4 model", prev[0], 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_gpr[i] = '0;
    m_epc = '0; m_en = 0;
    @(negedge clk_i);
    // R1: outputs under reset, with stimulus present
    tag = "R1";
    for (int i = 0; i < 4; i++) begin
      rs_idx_i = 5'(i * 7 + 1); rt_idx_i = 5'(31 - i);
      wr_en_i = 1; wr_idx_i = 5'(i + 3); wr_data_i = 32'hdead0000 + i;
      eret_i = 1; epc_wr_i = 1;
      cyc();
    end
    clr();
    rst_ni = 1;
    cyc();
    // R3: fill every register, read back
    tag = "R3";
    for (int i = 1; i < 32; i++) begin
      wr_en_i = 1; wr_idx_i = 5'(i); wr_data_i = 32'h1000_0000 * i + 32'h55 * i;
      rs_idx_i = 5'(i - 1); rt_idx_i = 5'(i);
      cyc();
    end
    clr();
    for (int i = 0; i < 32; i++) begin
      rs_idx_i = 5'(i); rt_idx_i = 5'(31 - i); cyc();
    end
    // R4 / R2: writes to index 0 ignored
    tag = "R4";
    wr_en_i = 1; wr_idx_i = 0; wr_data_i = 32'hffff_ffff; rs_idx_i = 0; rt_idx_i = 1;
    cyc();
    clr();
    tag = "R2"; rs_idx_i = 0; rt_idx_i = 0; cyc();
    // R5: read same register as written
    tag = "R5";
    wr_en_i = 1; wr_idx_i = 5; wr_data_i = 32'hcafe_f00d; rs_idx_i = 5; rt_idx_i = 5;
    cyc();
    clr(); cyc();
    // R11: enable low, data and index toggling
    tag = "R11";
    for (int i = 0; i < 4; i++) begin
      wr_idx_i = 5'(i + 5); wr_data_i = 32'h0bad_0000 + i; rs_idx_i = 5'(i + 5); rt_idx_i = 5'(i + 5);
      cyc();
    end
    // R9: moves
    tag = "R9";
    epc_wr_i = 1; wr_data_i = 32'h0000_4321; cyc();
    clr(); stat_wr_i = 1; wr_data_i = 32'h1; cyc();
    clr(); stat_wr_i = 1; wr_data_i = 32'h2; cyc();
    clr(); cyc();
    // R8: eret, and eret beating a status move of 0
    tag = "R8";
    eret_i = 1; cyc();
    clr(); stat_wr_i = 1; wr_data_i = 32'h1; cyc();
    clr(); eret_i = 1; stat_wr_i = 1; wr_data_i = 32'h0; cyc();
    clr(); cyc();
    // R7: interrupt colliding with every exception control
    tag = "R7";
    irq_take_i = 1; irq_pc_i = 32'h8000_0180; eret_i = 1; epc_wr_i = 1; stat_wr_i = 1;
    wr_data_i = 32'h7777_7777; wr_en_i = 1; wr_idx_i = 9; rs_idx_i = 9;
    cyc();
    clr(); cyc();
    eret_i = 1; cyc();
    clr(); irq_take_i = 1; irq_pc_i = 32'h0000_0abc; cyc();
    clr(); cyc();
    // R6: random independent reads and writes
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      rs_idx_i = 5'($urandom); rt_idx_i = 5'($urandom);
      wr_en_i = $urandom_range(0, 1); wr_idx_i = 5'($urandom); wr_data_i = $urandom;
      cyc();
    end
    // R10: random mix including exception controls
    tag = "R10";
    for (int i = 0; i < 600; i++) begin
      rs_idx_i = 5'($urandom); rt_idx_i = 5'($urandom);
      wr_en_i = $urandom_range(0, 1); wr_idx_i = 5'($urandom); wr_data_i = $urandom;
      epc_wr_i = ($urandom_range(0, 3) == 0); stat_wr_i = ($urandom_range(0, 3) == 0);
      eret_i = ($urandom_range(0, 5) == 0); irq_take_i = ($urandom_range(0, 5) == 0);
      irq_pc_i = $urandom;
      cyc();
    end
    clr(); cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule